// File: doc/BRIEF.md
# Reference-Clock Divider with Ready and Reset Conditioning

This block runs on a single fast reference clock, which stands in for a crystal oscillator, and produces the clocking and control lines for a processor. Its processor clock divides the reference by three and is high for one reference period out of every three. Its peripheral clock toggles once per processor clock period, so it runs at half the processor clock rate with an even duty cycle.

The block also conditions two control lines. Two ready requests from I/O circuits are ORed together and synchronized. The combined result reaches the processor only at the reference edge where the processor clock falls. An asynchronous reset request is synchronized into a reset output, which other peripherals may share. That output asserts as soon as the synchronized request is seen, and it releases only on a reference edge where the processor clock rises.

All state is clocked by the reference clock. The block has no clock of its own and no combinational path from an input to an output.

Top module: `clkgen_top`

## Requirements
- R1: `cpu_clk` rises once every DIV_RATIO (default 3) reference clock cycles.
- R2: `cpu_clk` stays high for HIGH_PHASES (default 1) reference cycles and low for the rest of its period.
- R3: `per_clk` has a period of 2*DIV_RATIO reference cycles and is high for exactly half of it.
- R4: `per_clk` changes only on a reference edge where `cpu_clk` rises, and it changes on every such edge.
- R5: While `rst_n` is low at a rising reference edge, the outputs are `cpu_clk`=0, `per_clk`=0, `cpu_ready`=0 and `cpu_reset`=1.
- R6: `cpu_ready` follows the logical OR of `rdy_req_a` and `rdy_req_b`. A change is not visible before the third reference edge after it, and it is visible by the SYNC_STAGES+DIV_RATIO'th edge (default 5).
- R7: `cpu_ready` changes only on a reference edge where `cpu_clk` falls.
- R8: `cpu_reset` becomes 1 on the SYNC_STAGES+1'th reference edge (default 3) after `rst_req` rises, and it stays 1 while `rst_req` is held.
- R9: `cpu_reset` falls only on a reference edge where `cpu_clk` rises, and it falls within SYNC_STAGES+DIV_RATIO reference edges after `rst_req` falls.
- R10: On the first reference edge after `rst_n` is released, both `cpu_clk` and `per_clk` go high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fast reference clock (crystal substitute) |
| rst_n | input | 1 | Synchronous active-low block reset |
| rdy_req_a | input | 1 | First asynchronous ready request from I/O |
| rdy_req_b | input | 1 | Second asynchronous ready request from I/O |
| rst_req | input | 1 | Asynchronous active-high reset request |
| cpu_clk | output | 1 | Processor clock, reference/3, one-third high |
| per_clk | output | 1 | Peripheral clock, half processor rate, 50% duty |
| cpu_ready | output | 1 | Synchronized, phase-aligned ready to the processor |
| cpu_reset | output | 1 | Synchronized active-high reset, shareable |

## Verification
The hardest cases to reach involve where a request change lands relative to the divider phase. The latency of `cpu_ready` and the release of `cpu_reset` both depend on how far away the next processor clock edge is. The stimulus therefore shifts the time of each change by zero to five reference cycles, which covers every phase of both derived clocks. At each of those offsets it applies all four combinations of the two ready inputs. A continuous monitor measures every edge-to-edge distance of the derived clocks in reference cycles, so the requests cannot disturb the dividers without being noticed.

// File: rtl/clkgen_pkg.sv
// Package: shared defaults and the phase strobe type for the clock generator.
// Assumes: consumers use the strobes in the same reference cycle they are driven.
package clkgen_pkg;

    localparam int DEF_DIV_RATIO   = 3;
    localparam int DEF_HIGH_PHASES = 1;
    localparam int DEF_SYNC_STAGES = 2;

    // Strobes that announce what the processor clock does at the coming edge.
    typedef struct packed {
        logic rise;
        logic fall;
    } phase_strb_t;

endpackage

// File: rtl/clkgen_phase.sv
// Module: clkgen_phase
// Counts reference cycles modulo DIV_RATIO and drives the registered processor
// clock, high for HIGH_PHASES cycles per period. It also emits strobes that
// say whether the processor clock rises or falls at the coming edge.
// Assumes: 1 <= HIGH_PHASES < DIV_RATIO, DIV_RATIO >= 2.
module clkgen_phase
    import clkgen_pkg::*;
#(
    parameter int DIV_RATIO   = DEF_DIV_RATIO,
    parameter int HIGH_PHASES = DEF_HIGH_PHASES
) (
    input  logic        ref_clk,
    input  logic        rst_n,
    output logic        cpu_clk,
    output phase_strb_t strb
);
    localparam int PW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV_RATIO - 1);
    localparam logic [PW-1:0] HIGH = PW'(HIGH_PHASES);

    logic [PW-1:0] ph_q;
    logic [PW-1:0] ph_nxt;

    // Next phase and the strobes derived from it.
    always_comb begin
        ph_nxt    = (ph_q == LAST) ? '0 : ph_q + 1'b1;
        strb.rise = (ph_nxt == '0);
        strb.fall = (ph_nxt == HIGH);
    end

    // Phase counter and registered processor clock; reset parks just before phase 0.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            ph_q    <= LAST;
            cpu_clk <= 1'b0;
        end else begin
            ph_q    <= ph_nxt;
            cpu_clk <= (ph_nxt < HIGH);
        end
    end

endmodule

// File: rtl/clkgen_sync.sv
// Module: clkgen_sync
// Multi-stage synchronizer for one asynchronous level into the reference domain.
// Assumes: STAGES >= 1; the input is a level held for at least one reference cycle.
module clkgen_sync #(
    parameter int STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    generate
        if (STAGES == 1) begin : g_single
            logic s_q;
            // Single capture flop.
            always_ff @(posedge ref_clk) begin
                if (!rst_n) s_q <= 1'b0;
                else        s_q <= din;
            end
            assign dout = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] s_q;
            // Shift the input through the chain of flops.
            always_ff @(posedge ref_clk) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= {s_q[STAGES-2:0], din};
            end
            assign dout = s_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/clkgen_toggle.sv
// Module: clkgen_toggle
// Peripheral clock: inverts on every edge where the processor clock rises,
// which gives half the processor rate at an even duty cycle.
// Assumes: strb comes from clkgen_phase in the same domain.
module clkgen_toggle
    import clkgen_pkg::*;
(
    input  logic        ref_clk,
    input  logic        rst_n,
    input  phase_strb_t strb,
    output logic        per_clk
);
    // Toggle on processor rising edges only.
    always_ff @(posedge ref_clk) begin
        if (!rst_n)         per_clk <= 1'b0;
        else if (strb.rise) per_clk <= ~per_clk;
    end

endmodule

// File: rtl/clkgen_ctrl.sv
// Module: clkgen_ctrl
// Conditions the control lines. The two ready requests are ORed, synchronized,
// and passed on only at a processor falling edge. The reset request is
// synchronized; the output asserts as soon as the request is seen and
// releases only at a processor rising edge.
// Assumes: request inputs are asynchronous levels.
module clkgen_ctrl
    import clkgen_pkg::*;
#(
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic        ref_clk,
    input  logic        rst_n,
    input  logic        rdy_req_a,
    input  logic        rdy_req_b,
    input  logic        rst_req,
    input  phase_strb_t strb,
    output logic        cpu_ready,
    output logic        cpu_reset
);
    logic rdy_any;
    logic rdy_s;
    logic rst_s;

    assign rdy_any = rdy_req_a | rdy_req_b;

    clkgen_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .din     (rdy_any),
        .dout    (rdy_s)
    );

    clkgen_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .din     (rst_req),
        .dout    (rst_s)
    );

    // Ready is updated only where the processor clock falls.
    always_ff @(posedge ref_clk) begin
        if (!rst_n)         cpu_ready <= 1'b0;
        else if (strb.fall) cpu_ready <= rdy_s;
    end

    // Reset asserts at once and releases on a processor rising edge.
    always_ff @(posedge ref_clk) begin
        if (!rst_n)         cpu_reset <= 1'b1;
        else if (rst_s)     cpu_reset <= 1'b1;
        else if (strb.rise) cpu_reset <= 1'b0;
    end

endmodule

// File: rtl/clkgen_top.sv
// Module: clkgen_top
// Top of the reference-clock divider: processor clock, peripheral clock,
// and the conditioned ready and reset outputs.
// Assumes: a single free-running reference clock; rst_n synchronous.
module clkgen_top
    import clkgen_pkg::*;
#(
    parameter int DIV_RATIO   = DEF_DIV_RATIO,
    parameter int HIGH_PHASES = DEF_HIGH_PHASES,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic rdy_req_a,
    input  logic rdy_req_b,
    input  logic rst_req,
    output logic cpu_clk,
    output logic per_clk,
    output logic cpu_ready,
    output logic cpu_reset
);
    phase_strb_t strb;

    clkgen_phase #(.DIV_RATIO(DIV_RATIO), .HIGH_PHASES(HIGH_PHASES)) u_phase (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .cpu_clk (cpu_clk),
        .strb    (strb)
    );

    clkgen_toggle u_toggle (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .strb    (strb),
        .per_clk (per_clk)
    );

    clkgen_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .rdy_req_a (rdy_req_a),
        .rdy_req_b (rdy_req_b),
        .rst_req   (rst_req),
        .strb      (strb),
        .cpu_ready (cpu_ready),
        .cpu_reset (cpu_reset)
    );

endmodule

// File: rtl/clkgen_checks.sv
// Module: clkgen_checks
// Property checks on the top-level outputs, attached to clkgen_top by bind.
// A counter measures the distance between processor clock edges, so that no
// check depends on a parameter-sized delay.
module clkgen_checks #(
    parameter int DIV_RATIO   = 3,
    parameter int HIGH_PHASES = 1
) (
    input logic ref_clk,
    input logic rst_n,
    input logic cpu_clk,
    input logic per_clk,
    input logic cpu_ready,
    input logic cpu_reset
);
    logic [15:0] gap_q;
    logic        seen_q;
    logic        cpu_q;

    // Reference cycles since the last observed processor rising edge.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            cpu_q  <= 1'b0;
        end else begin
            cpu_q <= cpu_clk;
            if (cpu_clk && !cpu_q) begin
                gap_q  <= 16'd1;
                seen_q <= 1'b1;
            end else if (gap_q != 16'hFFFF) begin
                gap_q <= gap_q + 16'd1;
            end
        end
    end

    a_r1_cpu_period: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (cpu_clk && !cpu_q && seen_q) |-> (gap_q == 16'(DIV_RATIO)));

    a_r2_cpu_high: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!cpu_clk && cpu_q && seen_q) |-> (gap_q == 16'(HIGH_PHASES)));

    a_r4_per_on_rise: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (per_clk != $past(per_clk)) |-> $rose(cpu_clk));

    a_r4_rise_toggles_per: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(cpu_clk) |-> (per_clk != $past(per_clk)));

    a_r7_ready_on_fall: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (cpu_ready != $past(cpu_ready)) |-> $fell(cpu_clk));

    a_r9_reset_release: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(cpu_reset) |-> $rose(cpu_clk));

endmodule

bind clkgen_top clkgen_checks #(
    .DIV_RATIO   (DIV_RATIO),
    .HIGH_PHASES (HIGH_PHASES)
) u_checks (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .cpu_clk   (cpu_clk),
    .per_clk   (per_clk),
    .cpu_ready (cpu_ready),
    .cpu_reset (cpu_reset)
);

// File: tb/clkgen_top_test.sv
`timescale 1ns/1ps
module clkgen_top_test;
    localparam int DIV  = 3;
    localparam int HIGH = 1;
    localparam int SYN  = 2;

    logic ref_clk = 1'b0;
    logic rst_n = 1'b0;
    logic rdy_req_a = 1'b0;
    logic rdy_req_b = 1'b0;
    logic rst_req = 1'b0;
    logic cpu_clk, per_clk, cpu_ready, cpu_reset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 ref_clk = ~ref_clk;

    clkgen_top #(.DIV_RATIO(DIV), .HIGH_PHASES(HIGH), .SYNC_STAGES(SYN)) uut (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .rdy_req_a (rdy_req_a),
        .rdy_req_b (rdy_req_b),
        .rst_req   (rst_req),
        .cpu_clk   (cpu_clk),
        .per_clk   (per_clk),
        .cpu_ready (cpu_ready),
        .cpu_reset (cpu_reset)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Edge monitor: measures edge distances in reference cycles at each negedge.
    int  n = 0;
    int  cpu_rise_at = -1;
    int  per_rise_at = -1;
    logic p_cpu = 1'b0, p_per = 1'b0, p_rdy = 1'b0, p_rst = 1'b1;
    always @(negedge ref_clk) begin
        if (rst_n) begin
            n++;
            if (cpu_clk && !p_cpu) begin
                if (cpu_rise_at >= 0) chk(n - cpu_rise_at == DIV, "R1 cpu_clk period", n - cpu_rise_at, DIV);
                cpu_rise_at = n;
            end
            if (!cpu_clk && p_cpu && cpu_rise_at >= 0)
                chk(n - cpu_rise_at == HIGH, "R2 cpu_clk high width", n - cpu_rise_at, HIGH);
            if (per_clk && !p_per) begin
                if (per_rise_at >= 0) chk(n - per_rise_at == 2*DIV, "R3 per_clk period", n - per_rise_at, 2*DIV);
                per_rise_at = n;
            end
            if (!per_clk && p_per && per_rise_at >= 0)
                chk(n - per_rise_at == DIV, "R3 per_clk high width", n - per_rise_at, DIV);
            if (per_clk != p_per)
                chk(cpu_clk && !p_cpu, "R4 per_clk edge aligned to cpu rise", int'(cpu_clk), 1);
            if (cpu_ready != p_rdy)
                chk(!cpu_clk && p_cpu, "R7 cpu_ready change on cpu fall", int'(p_cpu), 1);
            if (!cpu_reset && p_rst)
                chk(cpu_clk && !p_cpu, "R9 cpu_reset release on cpu rise", int'(cpu_clk), 1);
        end
        p_cpu = cpu_clk;
        p_per = per_clk;
        p_rdy = cpu_ready;
        p_rst = cpu_reset;
    end

    initial begin
        repeat (4) @(posedge ref_clk);
        @(negedge ref_clk);
        chk(cpu_clk == 1'b0, "R5 cpu_clk in reset", int'(cpu_clk), 0);
        chk(per_clk == 1'b0, "R5 per_clk in reset", int'(per_clk), 0);
        chk(cpu_ready == 1'b0, "R5 cpu_ready in reset", int'(cpu_ready), 0);
        chk(cpu_reset == 1'b1, "R5 cpu_reset in reset", int'(cpu_reset), 1);
        rst_n = 1'b1;
        @(negedge ref_clk);
        chk(cpu_clk == 1'b1, "R10 cpu_clk first edge", int'(cpu_clk), 1);
        chk(per_clk == 1'b1, "R10 per_clk first edge", int'(per_clk), 1);
        repeat (8) @(negedge ref_clk);
        chk(cpu_reset == 1'b0, "R9 cpu_reset released after init", int'(cpu_reset), 0);

        // Ready sweep: every phase offset times every request combination.
        for (int off = 0; off < 2*DIV; off++) begin
            for (int combo = 0; combo < 4; combo++) begin
                logic old_r;
                logic exp_r;
                repeat (off) @(negedge ref_clk);
                old_r = cpu_ready;
                exp_r = combo[0] | combo[1];
                rdy_req_a = combo[0];
                rdy_req_b = combo[1];
                for (int k = 1; k <= SYN + DIV; k++) begin
                    @(negedge ref_clk);
                    if (k <= SYN)
                        chk(cpu_ready == old_r, "R6 cpu_ready not early", int'(cpu_ready), int'(old_r));
                end
                chk(cpu_ready == exp_r, "R6 cpu_ready equals OR of requests", int'(cpu_ready), int'(exp_r));
                repeat (2*DIV) begin
                    @(negedge ref_clk);
                    chk(cpu_ready == exp_r, "R6 cpu_ready holds", int'(cpu_ready), int'(exp_r));
                end
            end
        end

        // Reset request sweep over every phase offset.
        for (int off = 0; off < 2*DIV; off++) begin
            repeat (off) @(negedge ref_clk);
            rst_req = 1'b1;
            for (int k = 1; k <= SYN + 1; k++) begin
                @(negedge ref_clk);
                if (k <= SYN) chk(cpu_reset == 1'b0, "R8 cpu_reset not early", int'(cpu_reset), 0);
            end
            chk(cpu_reset == 1'b1, "R8 cpu_reset asserted", int'(cpu_reset), 1);
            repeat (2*DIV) begin
                @(negedge ref_clk);
                chk(cpu_reset == 1'b1, "R8 cpu_reset held", int'(cpu_reset), 1);
            end
            rst_req = 1'b0;
            repeat (SYN + DIV) @(negedge ref_clk);
            chk(cpu_reset == 1'b0, "R9 cpu_reset released in time", int'(cpu_reset), 0);
        end

        repeat (12) @(negedge ref_clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge ref_clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule